// File: doc/BRIEF.md
# Position Frame Serializer with Inverted CRC

This block forms the single-cycle position word of a serial encoder slave and shifts it out one bit per master clock strobe. A start request captures a period count, an angle value and two error/warning flags into a shadow register. Configuration inputs are captured at the same moment. The block then presents the fields MSB first. The inverted CRC over those fields follows them, and an optional trailing zero bit comes last.

The configuration sets the counter width (none, short or long), the angle resolution (full width or one bit less), whether the 6-bit CRC is forced, and whether the zero bit is suppressed. The CRC width also follows the data length. Frames of 25 data bits or fewer use a 5-bit check unless the 6-bit check is forced; longer frames always use the 6-bit check. Line handling (start, acknowledge, timeout) sits outside the block. It pulses `start_i` once and then pulses `shift_i` once per bit.

Top module: `sdf_serializer`

## Requirements
- R1: After reset `busy_o` and `done_o` are 0 and `sdo_o` is 1. Whenever the block is idle, `sdo_o` is 1.
- R2: The data bits leave in this order: counter field, then angle field, then the two flag bits (`err_i[1]` first). Each field goes MSB first.
- R3: `cfg_cnt_sel_i` sets the counter field width: 0 gives none, 1 gives 8 bits (`count_i[7:0]`), 2 gives 24 bits, 3 gives none.
- R4: With `cfg_ang_full_i`=1 the angle field is 13 bits (`angle_i[12:0]`). With 0 it is 12 bits (`angle_i[11:0]`).
- R5: If the data length is 25 bits or less and the force bit is 0, a 5-bit CRC with polynomial x^5+x^2+1 is used. It starts from zero and is computed over the data bits in transmission order.
- R6: If `cfg_crc6_i`=1 or the data length exceeds 25 bits, a 6-bit CRC with polynomial x^6+x+1 is used instead, computed the same way.
- R7: The CRC follows the flag bits, MSB first, with every bit inverted.
- R8: A single 0 bit follows the CRC unless `cfg_nozero_i` was 1 at capture.
- R9: Changes to data or configuration inputs after the start cycle do not alter the frame in progress.
- R10: `start_i` is ignored while `busy_o` is 1.
- R11: The edge that shifts out the last bit ends the frame. In the next cycle `busy_o` is 0 and `done_o` is 1, and `done_o` stays high for that one cycle only.
- R12: The output bit advances only on a clock edge with `shift_i`=1. Between strobes it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture inputs and begin a frame (idle only) |
| shift_i | input | 1 | Advance one bit |
| count_i | input | 24 | Period count |
| angle_i | input | 13 | Angle value |
| err_i | input | 2 | Error / warning flags |
| cfg_cnt_sel_i | input | 2 | Counter width select |
| cfg_ang_full_i | input | 1 | 1: 13-bit angle, 0: 12-bit angle |
| cfg_crc6_i | input | 1 | Force the 6-bit CRC |
| cfg_nozero_i | input | 1 | Suppress the trailing zero bit |
| sdo_o | output | 1 | Serial data out |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at frame end |

## Verification
The properties assume that `start_i` and `shift_i` are clean synchronous strobes. They also assume that the surrounding line logic never expects a frame to restart in mid-flight, which is why output stability and continued busy are claimed between strobes. The stimulus keeps to this. Strobes are driven only at the falling edge. Random idle gaps of zero to two cycles separate the shift strobes. Start pulses, inserted on purpose, fall only in those gaps while a frame is running. The data and configuration inputs are scrambled after capture so the shadow copy is exercised.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
    typedef enum logic [1:0] {PH_IDLE, PH_DATA, PH_CRC, PH_ZERO} phase_e;
    typedef enum logic [1:0] {CRC_HOLD, CRC_CLEAR, CRC_FEED, CRC_DRAIN} crc_op_e;
endpackage

// File: rtl/sdf_layout.sv
module sdf_layout #(
    parameter int LONG_W      = 24,
    parameter int SHORT_W     = 8,
    parameter int ANG_W       = 13,
    parameter int AUTO6_ABOVE = 25,
    localparam int FRAME_W    = LONG_W + ANG_W + 2,
    localparam int LEN_W      = $clog2(FRAME_W + 1)
) (
    input  logic [LONG_W-1:0]  count_i,
    input  logic [ANG_W-1:0]   angle_i,
    input  logic [1:0]         err_i,
    input  logic [1:0]         cnt_sel_i,
    input  logic               ang_full_i,
    input  logic               crc6_force_i,
    output logic [FRAME_W-1:0] word_o,
    output logic [LEN_W-1:0]   len_o,
    output logic               crc6_o
);
    logic [LEN_W-1:0]   cw, aw;
    logic [FRAME_W-1:0] cmask, amask, right;

    always_comb begin
        case (cnt_sel_i)
            2'd1:    cw = LEN_W'(SHORT_W);
            2'd2:    cw = LEN_W'(LONG_W);
            default: cw = '0;
        endcase
        aw     = ang_full_i ? LEN_W'(ANG_W) : LEN_W'(ANG_W - 1);
        len_o  = cw + aw + LEN_W'(2);
        cmask  = (FRAME_W'(1) << cw) - FRAME_W'(1);
        amask  = (FRAME_W'(1) << aw) - FRAME_W'(1);
        right  = ((FRAME_W'(count_i) & cmask) << (aw + LEN_W'(2)))
               | ((FRAME_W'(angle_i) & amask) << 2)
               | FRAME_W'(err_i);
        word_o = right << (LEN_W'(FRAME_W) - len_o);
        crc6_o = crc6_force_i | (len_o > LEN_W'(AUTO6_ABOVE));
    end
endmodule

// File: rtl/sdf_crc.sv
module sdf_crc
    import sdf_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  crc_op_e op_i,
    input  logic    wide_i,
    input  logic    bit_i,
    output logic    tx_o
);
    logic [5:0] r_d, r_q;
    logic       fb;

    always_comb begin
        r_d = r_q;
        fb  = bit_i ^ (wide_i ? r_q[5] : r_q[4]);
        case (op_i)
            CRC_CLEAR: r_d = '0;
            CRC_FEED:  r_d = wide_i ? ({r_q[4:0], 1'b0} ^ ({6{fb}} & 6'h03))
                                    : ({1'b0, r_q[3:0], 1'b0} ^ ({6{fb}} & 6'h05));
            CRC_DRAIN: r_d = wide_i ? {r_q[4:0], 1'b0} : {1'b0, r_q[3:0], 1'b0};
            default:   r_d = r_q;
        endcase
        tx_o = ~(wide_i ? r_q[5] : r_q[4]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/sdf_serializer.sv
module sdf_serializer
    import sdf_pkg::*;
#(
    parameter int LONG_W      = 24,
    parameter int SHORT_W     = 8,
    parameter int ANG_W       = 13,
    parameter int AUTO6_ABOVE = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              shift_i,
    input  logic [LONG_W-1:0] count_i,
    input  logic [ANG_W-1:0]  angle_i,
    input  logic [1:0]        err_i,
    input  logic [1:0]        cfg_cnt_sel_i,
    input  logic              cfg_ang_full_i,
    input  logic              cfg_crc6_i,
    input  logic              cfg_nozero_i,
    output logic              sdo_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int FRAME_W = LONG_W + ANG_W + 2;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        phase_e             phase;
        logic [FRAME_W-1:0] word;
        logic [LEN_W-1:0]   len;
        logic [LEN_W-1:0]   idx;
        logic               crc6;
        logic               nozero;
        logic               done;
    } state_t;

    state_t             s_d, s_q;
    crc_op_e            crc_op;
    logic               crc_tx;
    logic [FRAME_W-1:0] lay_word;
    logic [LEN_W-1:0]   lay_len;
    logic               lay_crc6;

    sdf_layout #(
        .LONG_W(LONG_W), .SHORT_W(SHORT_W), .ANG_W(ANG_W), .AUTO6_ABOVE(AUTO6_ABOVE)
    ) u_layout (
        .count_i(count_i), .angle_i(angle_i), .err_i(err_i),
        .cnt_sel_i(cfg_cnt_sel_i), .ang_full_i(cfg_ang_full_i),
        .crc6_force_i(cfg_crc6_i),
        .word_o(lay_word), .len_o(lay_len), .crc6_o(lay_crc6)
    );

    sdf_crc u_crc (
        .clk(clk), .rst_n(rst_n), .op_i(crc_op), .wide_i(s_q.crc6),
        .bit_i(s_q.word[FRAME_W-1]), .tx_o(crc_tx)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        crc_op   = CRC_HOLD;
        case (s_q.phase)
            PH_IDLE: if (start_i) begin
                s_d.phase  = PH_DATA;
                s_d.word   = lay_word;
                s_d.len    = lay_len;
                s_d.crc6   = lay_crc6;
                s_d.nozero = cfg_nozero_i;
                s_d.idx    = '0;
                crc_op     = CRC_CLEAR;
            end
            PH_DATA: if (shift_i) begin
                crc_op   = CRC_FEED;
                s_d.word = s_q.word << 1;
                if (s_q.idx == s_q.len - LEN_W'(1)) begin
                    s_d.phase = PH_CRC;
                    s_d.idx   = '0;
                end else begin
                    s_d.idx = s_q.idx + LEN_W'(1);
                end
            end
            PH_CRC: if (shift_i) begin
                crc_op = CRC_DRAIN;
                if (s_q.idx == (s_q.crc6 ? LEN_W'(5) : LEN_W'(4))) begin
                    s_d.idx = '0;
                    if (s_q.nozero) begin
                        s_d.phase = PH_IDLE;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.phase = PH_ZERO;
                    end
                end else begin
                    s_d.idx = s_q.idx + LEN_W'(1);
                end
            end
            default: if (shift_i) begin
                s_d.phase = PH_IDLE;
                s_d.done  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (s_q.phase)
            PH_DATA: sdo_o = s_q.word[FRAME_W-1];
            PH_CRC:  sdo_o = crc_tx;
            PH_ZERO: sdo_o = 1'b0;
            default: sdo_o = 1'b1;
        endcase
        busy_o = (s_q.phase != PH_IDLE);
        done_o = s_q.done;
    end
endmodule

// File: rtl/sdf_serializer_chk.sv
module sdf_serializer_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic shift_i,
    input logic sdo_o,
    input logic busy_o,
    input logic done_o
);
    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> sdo_o);
    // R10
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !shift_i) |=> busy_o);
    // R12
    bit_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !shift_i) |=> $stable(sdo_o));
    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R11
    end_flags_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
endmodule

bind sdf_serializer sdf_serializer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .shift_i(shift_i),
    .sdo_o(sdo_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/sdf_serializer_test.sv
module sdf_serializer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, shift_i = 1'b0;
    logic [23:0] count_i = '0;
    logic [12:0] angle_i = '0;
    logic [1:0]  err_i = '0, cfg_cnt_sel_i = '0;
    logic        cfg_ang_full_i = 1'b0, cfg_crc6_i = 1'b0, cfg_nozero_i = 1'b0;
    logic        sdo_o, busy_o, done_o;

    int checks = 0, fails = 0;
    bit finished = 1'b0;
    logic exp_bits [0:63];
    int   exp_len, data_len, crc_len;

    sdf_serializer uut (.*);

    always #4 clk = ~clk;

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // Expected frame from the requirements: R3 counter width, R4 angle width,
    // R5/R6 polynomial choice, R7 inversion, R8 zero bit.
    task automatic build_expected(input logic [23:0] c, input logic [12:0] a,
                                  input logic [1:0] e, input logic [1:0] sel,
                                  input logic full, input logic f6, input logic nz);
        int cw, aw, w, n;
        logic [6:0] poly, r;
        logic top;
        cw = (sel == 2'd1) ? 8 : (sel == 2'd2) ? 24 : 0;
        aw = full ? 13 : 12;
        n = 0;
        for (int i = cw - 1; i >= 0; i--) begin exp_bits[n] = c[i]; n++; end
        for (int i = aw - 1; i >= 0; i--) begin exp_bits[n] = a[i]; n++; end
        exp_bits[n] = e[1]; n++;
        exp_bits[n] = e[0]; n++;
        data_len = n;
        w = (f6 || n > 25) ? 6 : 5;
        poly = (w == 6) ? 7'h43 : 7'h25;
        r = '0;
        for (int i = 0; i < data_len; i++) begin
            top = r[w-1] ^ exp_bits[i];
            r = (r << 1) & 7'((1 << w) - 1);
            if (top) r = r ^ (poly & 7'((1 << w) - 1));
        end
        for (int i = w - 1; i >= 0; i--) begin exp_bits[n] = ~r[i]; n++; end
        crc_len = w;
        if (!nz) begin exp_bits[n] = 1'b0; n++; end
        exp_len = n;
    endtask

    task automatic run_frame(input logic [23:0] c, input logic [12:0] a,
                             input logic [1:0] e, input logic [1:0] sel,
                             input logic full, input logic f6, input logic nz);
        string tag;
        build_expected(c, a, e, sel, full, f6, nz);
        @(negedge clk);
        count_i = c; angle_i = a; err_i = e; cfg_cnt_sel_i = sel;
        cfg_ang_full_i = full; cfg_crc6_i = f6; cfg_nozero_i = nz;
        start_i = 1'b1; shift_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        // R9: scramble everything after capture
        count_i = 24'($urandom); angle_i = 13'($urandom); err_i = 2'($urandom);
        cfg_cnt_sel_i = 2'($urandom); cfg_ang_full_i = 1'($urandom);
        cfg_crc6_i = 1'($urandom); cfg_nozero_i = 1'($urandom);
        check(busy_o, 1'b1, "R10 busy after start");
        for (int i = 0; i < exp_len; i++) begin
            tag = (i < data_len) ? "R2 data bit" :
                  (i < data_len + crc_len) ? "R7 crc bit" : "R8 zero bit";
            repeat ($urandom % 3) begin
                check(sdo_o, exp_bits[i], "R12 hold between strobes");
                start_i = 1'($urandom); // R10: ignored while busy
                shift_i = 1'b0;
                @(negedge clk);
            end
            check(sdo_o, exp_bits[i], tag);
            start_i = 1'b0; shift_i = 1'b1;
            @(negedge clk);
            shift_i = 1'b0;
        end
        check(done_o, 1'b1, "R11 done after last bit");
        check(busy_o, 1'b0, "R11 idle after last bit");
        @(negedge clk);
        check(done_o, 1'b0, "R11 done one cycle");
        check(sdo_o, 1'b1, "R1 idle line high");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(busy_o, 1'b0, "R1 busy at reset");
        check(done_o, 1'b0, "R1 done at reset");
        check(sdo_o, 1'b1, "R1 sdo at reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // Directed: every counter select (R3), both angle widths (R4),
        // 5-bit vs 6-bit CRC (R5, R6), zero bit on and off (R8)
        for (int s = 0; s < 4; s++)
            for (int f = 0; f < 2; f++)
                for (int z = 0; z < 2; z++)
                    run_frame(24'hA5C3F1, 13'h1ABC, 2'b10, 2'(s), 1'(f), 1'b0, 1'(z));
        run_frame(24'hFFFFFF, 13'h1FFF, 2'b11, 2'd2, 1'b1, 1'b0, 1'b0);
        run_frame('0, '0, 2'b00, 2'd0, 1'b0, 1'b0, 1'b0);
        run_frame('0, '0, 2'b00, 2'd1, 1'b1, 1'b1, 1'b1);
        run_frame(24'h0000FF, 13'h0001, 2'b01, 2'd1, 1'b1, 1'b1, 1'b0);
        for (int k = 0; k < 250; k++)
            run_frame(24'($urandom), 13'($urandom), 2'($urandom), 2'($urandom),
                      1'($urandom), 1'($urandom), 1'($urandom));
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule